// File: doc/BRIEF.md
# Packet Receive Queue with Threshold and End-of-Packet Availability

This block is a single-clock receive queue that sits between a link deframer and a streaming consumer. Each stored element is a data word of `ELEM_BYTES` bytes per lane across `LANES` lanes, together with its start-of-packet and end-of-packet markers. The consumer may keep its read request high all the time. A read that finds data returns the oldest element one cycle later with a valid strobe. A read on an empty queue does nothing.

A registered availability flag tells the consumer when enough data is waiting. In level mode the flag is high when the fill count is above a programmable low threshold. In packet mode the flag is also high while at least one end-of-packet word is held in the queue. A short packet whose length is below the threshold therefore still announces itself, and keeps the flag up until its last word has been read. With a high threshold, packet mode makes the queue store-and-forward, provided the depth holds at least one maximum-size packet. A write to a full queue is dropped and sets a sticky overflow flag.

Top module: `rxq_pkt_fifo`

## Requirements
- R1: Elements leave in the order they were written, each with the data, start marker and end marker that were written with it; an element is `8*ELEM_BYTES*LANES` bits of data.
- R2: With packet mode off, `avail` during the cycle after a clock edge equals (fill count after that edge > `lo_thresh` sampled at that edge).
- R3: A read request that finds data produces `rd_valid` high with that element exactly one cycle later, and `rd_valid` is never high without a read request in the previous cycle.
- R4: A read request on an empty queue gives `rd_valid` low the next cycle and changes neither the fill count nor the order of later data.
- R5: With packet mode on, `avail` is also high while at least one stored element carries an end marker, and it stays high until that element has been read.
- R6: When the queue holds `DEPTH` elements, `full` is high, a write is dropped, and `overflow` goes high and stays high until reset.
- R7: With `lo_thresh` = 0, `avail` rises in the cycle after the first word is written into an empty queue.
- R8: A write and a read in the same cycle on a queue that is neither empty nor full both take effect, and the fill count is unchanged.
- R9: After reset the queue is empty and `rd_valid`, `avail`, `full` and `overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request from the deframer |
| wr_data | input | 8*ELEM_BYTES*LANES | Write data word |
| wr_sop | input | 1 | Start-of-packet marker of the written word |
| wr_eop | input | 1 | End-of-packet marker of the written word |
| full | output | 1 | Queue holds DEPTH elements |
| overflow | output | 1 | Sticky: a write was dropped while full |
| rd_en | input | 1 | Read request, may be held high |
| lo_thresh | input | $clog2(DEPTH+1) | Low threshold for availability |
| pkt_mode | input | 1 | Enables end-of-packet availability |
| rd_valid | output | 1 | Read outputs carry an element |
| rd_data | output | 8*ELEM_BYTES*LANES | Read data word |
| rd_sop | output | 1 | Start marker of the read word |
| rd_eop | output | 1 | End marker of the read word |
| avail | output | 1 | Data-available flag |

## Verification
A wrong fill count shows within one cycle as a wrong `avail` once the threshold is near the level, and as a wrong `full` on the write side. It shows later as a missing or extra `rd_valid` when the queue drains. A wrong end-marker count leaves `avail` high after the last packet tail has gone, or low while a short packet waits, in the cycle after the edge that mishandled it. Pointer faults show as reordered or repeated data on the first read after the corruption.

// File: rtl/rxq_pkt_fifo.sv
module rxq_pkt_fifo #(
  parameter int ELEM_BYTES = 2,
  parameter int LANES      = 1,
  parameter int DEPTH      = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [8*ELEM_BYTES*LANES-1:0]     wr_data,
  input  logic                              wr_sop,
  input  logic                              wr_eop,
  output logic                              full,
  output logic                              overflow,
  input  logic                              rd_en,
  input  logic [$clog2(DEPTH+1)-1:0]        lo_thresh,
  input  logic                              pkt_mode,
  output logic                              rd_valid,
  output logic [8*ELEM_BYTES*LANES-1:0]     rd_data,
  output logic                              rd_sop,
  output logic                              rd_eop,
  output logic                              avail
);
  localparam int DW = 8 * ELEM_BYTES * LANES;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW+1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt, cnt_n, ecnt, ecnt_n;
  logic          do_wr, do_rd, head_eop;

  assign full     = (cnt == CW'(DEPTH));
  assign do_wr    = wr_en && !full;
  assign do_rd    = rd_en && (cnt != '0);
  assign head_eop = mem[rptr][0];

  always_comb begin
    cnt_n = cnt;
    if (do_wr && !do_rd) cnt_n = cnt + 1'b1;
    if (do_rd && !do_wr) cnt_n = cnt - 1'b1;
    ecnt_n = ecnt;
    if ((do_wr && wr_eop) && !(do_rd && head_eop)) ecnt_n = ecnt + 1'b1;
    if ((do_rd && head_eop) && !(do_wr && wr_eop)) ecnt_n = ecnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= {wr_data, wr_sop, wr_eop};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      cnt      <= '0;
      ecnt     <= '0;
      overflow <= 1'b0;
      avail    <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_sop   <= 1'b0;
      rd_eop   <= 1'b0;
    end else begin
      cnt      <= cnt_n;
      ecnt     <= ecnt_n;
      rd_valid <= do_rd;
      avail    <= (cnt_n > lo_thresh) || (pkt_mode && ecnt_n != '0);
      if (wr_en && full) overflow <= 1'b1;
      if (do_wr) wptr <= wptr + 1'b1;
      if (do_rd) begin
        rptr                      <= rptr + 1'b1;
        {rd_data, rd_sop, rd_eop} <= mem[rptr];
      end
    end
  end
endmodule

// File: rtl/rxq_pkt_fifo_chk.sv
module rxq_pkt_fifo_chk #(
  parameter int CW    = 4,
  parameter int DEPTH = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          full,
  input logic          overflow,
  input logic          rd_valid,
  input logic          avail,
  input logic          pkt_mode,
  input logic [CW-1:0] lo_thresh,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] ecnt
);
  p_valid_needs_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));

  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && rd_en) |=> (!rd_valid && cnt == $past(cnt) + CW'($past(wr_en))));

  p_overflow_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en) |=> overflow);

  p_overflow_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_level_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH) && ecnt <= cnt);

  p_level_avail_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!pkt_mode) |-> (avail == (cnt > $past(lo_thresh))));

  p_eop_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pkt_mode) && ecnt != '0) |-> avail);
endmodule

bind rxq_pkt_fifo rxq_pkt_fifo_chk #(.CW(CW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .full(full),
  .overflow(overflow), .rd_valid(rd_valid), .avail(avail), .pkt_mode(pkt_mode),
  .lo_thresh(lo_thresh), .cnt(cnt), .ecnt(ecnt)
);

// File: tb/sim_rxq_pkt_fifo.sv
module sim_rxq_pkt_fifo;
  localparam int PER = 10;
  localparam int DW  = 16;
  localparam int CW  = 4;

  typedef struct packed {
    logic          wr;
    logic          sop;
    logic          eop;
    logic [DW-1:0] d;
    logic          rd;
    logic [CW-1:0] thr;
    logic          mode;
    logic          ev;
    logic [DW-1:0] ed;
    logic          eeop;
    logic          eav;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b1, 1'b0, 16'hA001, 1'b0, 4'd3, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b1, 16'hA002, 1'b0, 4'd3, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0},
    '{1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 4'd3, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1},
    '{1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 4'd3, 1'b1, 1'b1, 16'hA001, 1'b0, 1'b1},
    '{1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 4'd3, 1'b1, 1'b1, 16'hA002, 1'b1, 1'b0},
    '{1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 4'd3, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0},
    '{1'b1, 1'b1, 1'b0, 16'hB001, 1'b0, 4'd0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1},
    '{1'b1, 1'b0, 1'b0, 16'hB002, 1'b1, 4'd0, 1'b0, 1'b1, 16'hB001, 1'b0, 1'b1},
    '{1'b1, 1'b0, 1'b1, 16'hB003, 1'b0, 4'd1, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1},
    '{1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 4'd1, 1'b0, 1'b1, 16'hB002, 1'b0, 1'b0},
    '{1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 4'd1, 1'b0, 1'b1, 16'hB003, 1'b1, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sop = 1'b0, wr_eop = 1'b0, rd_en = 1'b0, pkt_mode = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [CW-1:0] lo_thresh = '0;
  logic full, overflow, rd_valid, rd_sop, rd_eop, avail;
  logic [DW-1:0] rd_data;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #(PER/2) clk = ~clk;

  rxq_pkt_fifo u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_sop(wr_sop),
    .wr_eop(wr_eop), .full(full), .overflow(overflow), .rd_en(rd_en),
    .lo_thresh(lo_thresh), .pkt_mode(pkt_mode), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_sop(rd_sop), .rd_eop(rd_eop), .avail(avail)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic [DW-1:0] d, input logic s, input logic e,
                     input logic r);
    wr_en = w; wr_data = d; wr_sop = s; wr_eop = e; rd_en = r;
    @(posedge clk); #1;
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    chk("R9 valid", DW'(rd_valid), 0);
    chk("R9 avail", DW'(avail), 0);
    chk("R9 full", DW'(full), 0);
    chk("R9 overflow", DW'(overflow), 0);

    for (int i = 0; i < NV; i++) begin
      lo_thresh = TBL[i].thr; pkt_mode = TBL[i].mode;
      cyc(TBL[i].wr, TBL[i].d, TBL[i].sop, TBL[i].eop, TBL[i].rd);
      chk($sformatf("R3 R4 valid row %0d", i), DW'(rd_valid), DW'(TBL[i].ev));
      if (TBL[i].ev) begin
        chk($sformatf("R1 R8 data row %0d", i), rd_data, TBL[i].ed);
        chk($sformatf("R1 eop row %0d", i), DW'(rd_eop), DW'(TBL[i].eeop));
      end
      chk($sformatf("R2 R5 R7 avail row %0d", i), DW'(avail), DW'(TBL[i].eav));
    end

    lo_thresh = 4'd7; pkt_mode = 1'b0;
    for (int i = 0; i < 8; i++) begin
      cyc(1'b1, DW'(16'hC000 + i), i == 0, 1'b0, 1'b0);
      chk($sformatf("R2 avail fill %0d", i + 1), DW'(avail), DW'(i == 7));
    end
    chk("R6 full at depth", DW'(full), 1);
    chk("R6 no overflow yet", DW'(overflow), 0);
    cyc(1'b1, 16'hDEAD, 1'b0, 1'b0, 1'b0);
    chk("R6 overflow set", DW'(overflow), 1);
    chk("R6 still full", DW'(full), 1);
    for (int i = 0; i < 8; i++) begin
      cyc(1'b0, '0, 1'b0, 1'b0, 1'b1);
      chk($sformatf("R1 R6 drain valid %0d", i), DW'(rd_valid), 1);
      chk($sformatf("R1 R6 drain data %0d", i), rd_data, DW'(16'hC000 + i));
      chk($sformatf("R1 drain sop %0d", i), DW'(rd_sop), DW'(i == 0));
    end
    cyc(1'b0, '0, 1'b0, 1'b0, 1'b1);
    chk("R4 R6 dropped word absent", DW'(rd_valid), 0);
    chk("R6 overflow sticky", DW'(overflow), 1);
    chk("R6 not full after drain", DW'(full), 0);

    do_reset();
    chk("R9 overflow cleared", DW'(overflow), 0);
    chk("R9 valid after reset", DW'(rd_valid), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule